// File: doc/BRIEF.md
# Prescaled Dual-Channel Pulse-Width Modulator

This block generates one or two pulse-width modulated outputs from a single clock. Each channel has a 6-bit clock prescaler and a 10-bit period counter. The period counter advances once per prescaled tick. The output is high from the start of each period until the counter reaches the programmed duty count. A separate flag forces the output high for the whole period. Software programs each channel through a small write/read register bus. A per-channel enable input starts the channel or stops it.

Each channel runs a three-state controller with the states IDLE, RUN and DRAIN. The transitions are:
- START (IDLE to RUN): enable is seen high.
- HALT (RUN or DRAIN to IDLE): enable is low and abrupt shutdown is selected.
- WIND_DOWN (RUN to DRAIN): enable is low and graceful shutdown is selected.
- RESUME (DRAIN to RUN): enable returns high.
- STOP (DRAIN to IDLE): the current period ends.

The prescale, period and duty values that drive the counters are copied from the registers only at START and at each period wrap. A write made while the channel runs therefore never produces a cut or stretched pulse.

Top module: `pwm_dual_core`

## Requirements
- R1: After reset every output is low and every register reads zero.
- R2: Within a channel, the control word sits at offset 0x0, with the prescale value in bits 5:0 and the shutdown-mode bit in bit 6. The duty word sits at 0x4, with the duty count in bits 9:0 and the full-high flag in bit 10. The period word sits at 0x8, in bits 9:0. A read returns the last value written to those fields, and every other bit reads zero.
- R3: The second channel's words sit at the first channel's offsets plus 0x10. The offsets 0x0C and 0x1C, and any address with a bit above bit 4 set, read zero and ignore writes. With the dual-channel parameter off, the 0x10 range behaves the same way.
- R4: The output period is (prescale+1)*(period+1) clock cycles.
- R5: The output is high for (prescale+1)*duty clock cycles at the start of each period and low for the rest of the period.
- R6: When the full-high flag is set, the output stays high for the whole period, whatever the duty count is.
- R7: A duty count of 0 with the flag clear keeps the output low. A duty count above the period value keeps the output high.
- R8: Duty, period and prescale values written while the channel runs take effect only at the next period start.
- R9: With the shutdown bit at 1, dropping the enable drives the output low at the next clock edge, and it stays low.
- R10: With the shutdown bit at 0, dropping the enable lets the current period finish unchanged, after which the output stays low. Raising the enable again before the period ends continues the same waveform without a restart.
- R11: The two channels run independently, and a write to one channel does not alter the other.
- R12: A period starts in the cycle after the enable is sampled high, and the output is high in that first cycle when the duty count is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the counters and registers |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | AW | Byte address of the register for the write and the read |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Contents of the register at bus_addr, valid in the same cycle |
| chan_en | input | NCH | Per-channel enable |
| pwm_out | output | NCH | Per-channel modulated output |

## Verification
The hardest situations to reach are the two shutdown corner cases. One is a graceful stop that is reversed while the channel is in DRAIN. The other is a duty write that lands in the middle of a period. Both need the bench to know the counter phase exactly. The bench gets this by always starting a channel from IDLE with the enable driven on a known falling edge, so the period starts at a fixed cycle. It then drops, raises or rewrites values at chosen cycle offsets. A restarted waveform, or a duty change applied too early, shows up as a wrong level at a sampled offset. Pulse widths and periods in the steady state are compared against a queue of expected pulses, which are computed from the prescale, period and duty formulas.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int PRE_W    = 6;
    localparam int CNT_W    = 10;
    localparam int SD_BIT   = 6;
    localparam int FULL_BIT = 10;
    localparam int CH_BIT   = 4;
    localparam int OFS_W    = CH_BIT;
    localparam logic [OFS_W-1:0] OFS_CTRL   = 4'h0;
    localparam logic [OFS_W-1:0] OFS_DUTY   = 4'h4;
    localparam logic [OFS_W-1:0] OFS_PERIOD = 4'h8;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_DRAIN = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic             sd_abrupt;
        logic [CNT_W-1:0] duty;
        logic             full;
        logic [CNT_W-1:0] period;
    } ch_cfg_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    assign tick = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_regbank.sv
module pwm_regbank
    import pwm_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    output ch_cfg_t [NCH-1:0]     cfg
);
    localparam int HI_W = AW - CH_BIT - 1;

    logic             in_range;
    logic             ch_idx;
    logic [OFS_W-1:0] ofs;
    logic [NCH-1:0]   hit;
    logic [DW-1:0]    rd_part [NCH];
    wire              unused_wdata = ^wdata[DW-1:FULL_BIT+1];

    assign in_range = (addr[AW-1:CH_BIT+1] == {HI_W{1'b0}});
    assign ch_idx   = addr[CH_BIT];
    assign ofs      = addr[OFS_W-1:0];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign hit[g] = in_range && (ch_idx == g[0]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[g] <= '0;
            end else if (we && hit[g]) begin
                unique case (ofs)
                    OFS_CTRL: begin
                        cfg[g].presc     <= wdata[PRE_W-1:0];
                        cfg[g].sd_abrupt <= wdata[SD_BIT];
                    end
                    OFS_DUTY: begin
                        cfg[g].duty <= wdata[CNT_W-1:0];
                        cfg[g].full <= wdata[FULL_BIT];
                    end
                    OFS_PERIOD: begin
                        cfg[g].period <= wdata[CNT_W-1:0];
                    end
                    default: ;
                endcase
            end
        end

        always_comb begin
            rd_part[g] = '0;
            if (hit[g]) begin
                unique case (ofs)
                    OFS_CTRL: begin
                        rd_part[g][PRE_W-1:0] = cfg[g].presc;
                        rd_part[g][SD_BIT]    = cfg[g].sd_abrupt;
                    end
                    OFS_DUTY: begin
                        rd_part[g][CNT_W-1:0] = cfg[g].duty;
                        rd_part[g][FULL_BIT]  = cfg[g].full;
                    end
                    OFS_PERIOD: begin
                        rd_part[g][CNT_W-1:0] = cfg[g].period;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            rdata = rdata | rd_part[i];
        end
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  ch_cfg_t cfg,
    output logic    out,
    output logic    busy,
    output logic    full_act
);
    ch_state_e        st_q, st_d;
    logic [PRE_W-1:0] presc_s;
    logic [CNT_W-1:0] pv_s, duty_s, per_q;
    logic             full_s;
    logic             tick, wrap, start, load;

    assign busy     = (st_q != CH_IDLE);
    assign full_act = full_s;
    assign wrap     = tick && (per_q == pv_s);
    assign start    = (st_q == CH_IDLE) && en;
    assign load     = start || (busy && wrap);

    pwm_prescaler #(.W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .limit (presc_s),
        .tick  (tick)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    // transitions: START, HALT, WIND_DOWN, RESUME, STOP
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE: begin
                if (en) st_d = CH_RUN;
            end
            CH_RUN: begin
                if (!en) st_d = cfg.sd_abrupt ? CH_IDLE : CH_DRAIN;
            end
            CH_DRAIN: begin
                if (en)                         st_d = CH_RUN;
                else if (cfg.sd_abrupt || wrap) st_d = CH_IDLE;
            end
            default: st_d = CH_IDLE;
        endcase
    end

    // shadow copies taken at period boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_s <= '0;
            pv_s    <= '0;
            duty_s  <= '0;
            full_s  <= 1'b0;
        end else if (load) begin
            presc_s <= cfg.presc;
            pv_s    <= cfg.period;
            duty_s  <= cfg.duty;
            full_s  <= cfg.full;
        end
    end

    // period counter
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            per_q <= '0;
        end else if (tick) begin
            per_q <= wrap ? '0 : per_q + 1'b1;
        end
    end

    // output decode
    always_comb begin
        out = 1'b0;
        unique case (st_q)
            CH_IDLE:          out = 1'b0;
            CH_RUN, CH_DRAIN: out = full_s || (per_q < duty_s);
            default:          out = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_dual_core.sv
module pwm_dual_core
    import pwm_pkg::*;
#(
    parameter bit DUAL = 1'b1,
    parameter int AW   = 8,
    parameter int DW   = 32,
    localparam int NCH = DUAL ? 2 : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] chan_en,
    output logic [NCH-1:0] pwm_out
);
    ch_cfg_t [NCH-1:0] cfg;
    logic [NCH-1:0]    sd_vec;
    logic [NCH-1:0]    busy_vec;
    logic [NCH-1:0]    full_vec;

    pwm_regbank #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .cfg   (cfg)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign sd_vec[g] = cfg[g].sd_abrupt;
        pwm_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (chan_en[g]),
            .cfg      (cfg[g]),
            .out      (pwm_out[g]),
            .busy     (busy_vec[g]),
            .full_act (full_vec[g])
        );
    end
endmodule

// File: rtl/pwm_dual_core_chk.sv
module pwm_dual_core_chk #(
    parameter int NCH = 2,
    parameter int DW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] chan_en,
    input logic [NCH-1:0] pwm_out,
    input logic [DW-1:0]  bus_rdata,
    input logic [NCH-1:0] sd_vec,
    input logic [NCH-1:0] busy_vec,
    input logic [NCH-1:0] full_vec
);
    AST_RD_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) bus_rdata[DW-1:11] == '0); // R2

    for (genvar g = 0; g < NCH; g++) begin : g_a
        AST_ABRUPT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
            (!chan_en[g] && sd_vec[g]) |=> !pwm_out[g]); // R9
        AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_vec[g] && full_vec[g]) |-> pwm_out[g]); // R6
        AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (!chan_en[g] && !busy_vec[g]) |=> !pwm_out[g]); // R10
        AST_START_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy_vec[g]) |-> $past(chan_en[g])); // R12
    end
endmodule

bind pwm_dual_core pwm_dual_core_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .pwm_out   (pwm_out),
    .bus_rdata (bus_rdata),
    .sd_vec    (sd_vec),
    .busy_vec  (busy_vec),
    .full_vec  (full_vec)
);

// File: tb/pwm_dual_core_test.sv
module pwm_dual_core_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  chan_en = '0;
    logic [1:0]  pwm_out;

    int n_run = 0;
    int n_fail = 0;

    typedef struct {int hi; int per; string req;} pulse_t;
    pulse_t exp_q[$];
    bit mon_on = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pwm_dual_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .chan_en   (chan_en),
        .pwm_out   (pwm_out)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        bus_we = 1'b1; bus_addr = a[7:0]; bus_wdata = d;
        tick(1);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input int a, input int exp);
        bus_addr = a[7:0];
        #1;
        check(req, int'(bus_rdata), exp);
    endtask

    task automatic push_pulses(input int n, input int hi, input int per, input string req);
        for (int i = 0; i < n; i++) exp_q.push_back('{hi, per, req});
    endtask

    task automatic count_high(input int ch, input int n, output int k);
        k = 0;
        for (int i = 0; i < n; i++) begin
            k += int'(pwm_out[ch]);
            tick(1);
        end
    endtask

    // scoreboard monitor on channel 0
    bit prev = 1'b0, have_rise = 1'b0;
    int since = 0, hi_run = 0, hi_last = 0;
    always @(negedge clk) begin
        if (!mon_on) begin
            prev = 1'b0; have_rise = 1'b0; since = 0; hi_run = 0;
        end else begin
            if (pwm_out[0] && !prev) begin
                if (have_rise) begin
                    if (exp_q.size() == 0) begin
                        check("R4 unexpected pulse", 1, 0);
                    end else begin
                        pulse_t e;
                        e = exp_q.pop_front();
                        check({e.req, " period"}, since, e.per);
                        check({e.req, " high"}, hi_last, e.hi);
                    end
                end
                have_rise = 1'b1; since = 0; hi_run = 0;
            end
            if (!pwm_out[0] && prev) hi_last = hi_run;
            since++;
            if (pwm_out[0]) hi_run++;
            prev = pwm_out[0];
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int k;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 outputs", int'(pwm_out), 0);
        rd_check("R1 duty0", 'h04, 0);
        rd_check("R1 period1", 'h18, 0);

        // R2 field widths
        wr('h00, 32'hFFFF_FFFF); rd_check("R2 ctrl", 'h00, 'h7F);
        wr('h04, 32'hFFFF_FFFF); rd_check("R2 duty", 'h04, 'h7FF);
        wr('h08, 32'hFFFF_FFFF); rd_check("R2 period", 'h08, 'h3FF);
        // R3 mirror and holes
        wr('h14, 'h123); rd_check("R3 ch1 duty", 'h14, 'h123);
        rd_check("R3 ch0 untouched", 'h04, 'h7FF);
        wr('h0C, 32'hFFFF); rd_check("R3 hole", 'h0C, 0);
        wr('h1C, 32'hFFFF); rd_check("R3 hole1", 'h1C, 0);
        wr('h24, 5); rd_check("R3 high addr", 'h24, 0);
        rd_check("R3 no alias", 'h04, 'h7FF);

        // R4/R5 scoreboard: P=2 PV=9 DC=4 -> period 30, high 12
        wr('h00, 2); wr('h04, 4); wr('h08, 9);
        push_pulses(3, 12, 30, "R4/R5 p2");
        mon_on = 1'b1; chan_en[0] = 1'b1;
        tick(95);
        check("R4 pulses consumed", exp_q.size(), 0);
        mon_on = 1'b0; chan_en[0] = 1'b0;
        tick(40);
        // P=0 PV=4 DC=1 -> period 5, high 1
        wr('h00, 0); wr('h04, 1); wr('h08, 4);
        push_pulses(4, 1, 5, "R5 p0");
        mon_on = 1'b1; chan_en[0] = 1'b1;
        tick(23);
        check("R5 pulses consumed", exp_q.size(), 0);
        mon_on = 1'b0; chan_en[0] = 1'b0;
        tick(10);

        // R12 and R8: P=0 PV=9 DC=5, duty rewritten mid-period
        wr('h04, 5); wr('h08, 9);
        chan_en[0] = 1'b1;
        tick(1); check("R12 first cycle high", int'(pwm_out[0]), 1);
        tick(2); wr('h04, 8);
        tick(3); check("R8 old duty kept", int'(pwm_out[0]), 0);
        tick(10); check("R8 new duty high", int'(pwm_out[0]), 1);
        tick(2); check("R8 new duty low", int'(pwm_out[0]), 0);

        // R9 abrupt stop
        wr('h00, 'h40);
        for (int i = 0; i < 30 && !pwm_out[0]; i++) tick(1);
        chan_en[0] = 1'b0;
        tick(1); check("R9 low next clock", int'(pwm_out[0]), 0);
        tick(5); check("R9 stays low", int'(pwm_out[0]), 0);

        // R10 graceful stop, duty 5 PV 9
        wr('h00, 0); wr('h04, 5);
        chan_en[0] = 1'b1;
        tick(3); chan_en[0] = 1'b0;
        tick(1); check("R10 period continues", int'(pwm_out[0]), 1);
        tick(7); check("R10 low after period", int'(pwm_out[0]), 0);
        tick(5); check("R10 stays low", int'(pwm_out[0]), 0);
        // R10 resume during drain
        chan_en[0] = 1'b1;
        tick(3); chan_en[0] = 1'b0;
        tick(2); chan_en[0] = 1'b1;
        tick(2); check("R10 resume no restart", int'(pwm_out[0]), 0);
        tick(4); check("R10 resume next period", int'(pwm_out[0]), 1);
        chan_en[0] = 1'b0;
        tick(12);

        // R6 full flag with duty 3
        wr('h04, 'h403);
        chan_en[0] = 1'b1; tick(1);
        count_high(0, 20, k); check("R6 full high", k, 20);
        chan_en[0] = 1'b0; tick(12);
        // R7 zero duty and saturation
        wr('h04, 0);
        chan_en[0] = 1'b1; tick(1);
        count_high(0, 20, k); check("R7 zero duty", k, 0);
        chan_en[0] = 1'b0; tick(12);
        wr('h04, 15);
        chan_en[0] = 1'b1; tick(1);
        count_high(0, 20, k); check("R7 saturate", k, 20);
        chan_en[0] = 1'b0; tick(12);

        // R11 second channel: P=1 PV=3 DC=2 -> high 4, period 8
        wr('h10, 1); wr('h14, 2); wr('h18, 3);
        rd_check("R11 ch0 duty intact", 'h04, 15);
        chan_en[1] = 1'b1;
        tick(1);
        check("R11 ch1 high", int'(pwm_out[1]), 1);
        check("R11 ch0 idle", int'(pwm_out[0]), 0);
        tick(5); check("R11 ch1 low", int'(pwm_out[1]), 0);
        tick(3); check("R11 ch1 next period", int'(pwm_out[1]), 1);
        chan_en[1] = 1'b0;
        tick(10);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule